// File: doc/BRIEF.md
# Post-Modify Load Address Generator

This unit sits beside a load pipeline and turns one decoded load into two numbers: the byte address the memory access should use, and the value the pointer register should hold afterwards. A four-bit mode select picks one of eight addressing schemes. Two of them leave the pointer alone. The other six write it back. These six cover an absolute pointer set, a plain post-increment by an immediate or by a modifier register, a bit-reversed post-increment for FFT-style walks, and two circular-buffer walks that wrap inside a window described by a start register and a length.

The operand inputs are the current pointer or base, an immediate, an index with a shift amount, a modifier register, a circular-start register and an access-size flag. The address arithmetic is purely combinational. By default a register stage follows it, so the address, the new pointer and the writeback enable appear one clock after the operands. Fetching the data, unpacking it and storing anything into a register file are left to neighbouring blocks.

Top module: `post_modify_agu`

## Requirements
- R1: Mode 0 (offset): the address is ptr + imm, wb_en is 0 and new_ptr equals ptr.
- R2: Mode 1 (scaled index): the address is (idx << shamt) + imm, where imm acts as an absolute base. wb_en is 0 and new_ptr equals ptr.
- R3: Mode 2 (absolute set): the address is imm, new_ptr is also imm, and wb_en is 1.
- R4: Mode 3 (register post-increment): the address is ptr, new_ptr is ptr + modr, and wb_en is 1.
- R5: Mode 4 (immediate post-increment): the address is ptr, new_ptr is ptr + imm, and wb_en is 1.
- R6: Mode 5 (bit-reversed): address bits 15:0 are ptr bits 15:0 in reversed order, and the bits above them are copied from ptr unchanged. new_ptr is ptr + modr, formed from the unreversed ptr, and wb_en is 1.
- R7: In mode 5 with modr = 0x1000 and a 64K-aligned starting pointer, four successive loads use byte offsets 0, 8, 4 and 12.
- R8: Mode 6 (circular, immediate step): the address is ptr. The step is imm and the window length is modr bits 16:0, starting at cstart. new_ptr is ptr + step, less the length if the result reaches start + length. With length 6 and step 2, the offsets run 0, 2, 4, 0.
- R9: Mode 7 (circular, register step): the window length is modr bits 16:0. A two's-complement step count sits in modr bits 23:17. The step in bytes is that count times 2 when sz4 = 0, or times 4 when sz4 = 1. With length 8, count 2 and sz4 = 0, the offsets run 0, 4, 0, 4.
- R10: In either circular mode, if ptr + step falls below cstart, the length is added, so a negative step wraps back into the window.
- R11: Mode values 8 to 15 give address 0 and wb_en 0, with new_ptr equal to ptr.
- R12: With OUT_REG = 1, all three outputs are registered and show the result of the operands present at the previous rising clock edge. While rst_n is low they are held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register stage |
| rst_n | input | 1 | Active-low reset of the output stage |
| mode | input | 4 | Addressing mode select (see R1 to R11) |
| ptr | input | ADDR_W | Current pointer or base register value |
| imm | input | ADDR_W | Immediate offset, increment or absolute value |
| idx | input | ADDR_W | Index for scaled-index mode |
| shamt | input | $clog2(ADDR_W) | Left shift applied to idx |
| modr | input | ADDR_W | Modifier register (increment, or packed count and length) |
| cstart | input | ADDR_W | Circular-buffer start address |
| sz4 | input | 1 | Access size: 0 for 2 bytes, 1 for 4 bytes |
| ea | output | ADDR_W | Effective load address |
| new_ptr | output | ADDR_W | Updated pointer value |
| wb_en | output | 1 | Pointer writeback enable |

## Verification
The bench uses the default parameters: 32-bit addresses, a 17-bit length field, a 7-bit step count, a 16-bit reversal window and the output register enabled. With these values, the packed modifier fields sit exactly at bits 16:0 and 23:17, and the bit-reversed walk from a 64K-aligned base yields the 0, 8, 4, 12 pattern. The registered outputs also make the one-cycle latency and the zero values under reset visible. Pointer chains are fed back by the bench's own model, so both circular modes are exercised across their wrap points in both directions, using both access sizes.

// File: rtl/agu_pkg.sv
package agu_pkg;
  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    AM_OFFSET  = 4'd0,
    AM_SCALED  = 4'd1,
    AM_ABSSET  = 4'd2,
    AM_POSTREG = 4'd3,
    AM_POSTIMM = 4'd4,
    AM_BITREV  = 4'd5,
    AM_CIRCIMM = 4'd6,
    AM_CIRCREG = 4'd7
  } amode_e;
endpackage

// File: rtl/agu_bitrev.sv
module agu_bitrev #(
  parameter int ADDR_W = 32,
  parameter int BREV_W = 16
) (
  input  logic [ADDR_W-1:0] din,
  output logic [ADDR_W-1:0] dout
);
  for (genvar i = 0; i < BREV_W; i++) begin : g_rev
    assign dout[i] = din[BREV_W-1-i];
  end
  if (ADDR_W > BREV_W) begin : g_upper
    assign dout[ADDR_W-1:BREV_W] = din[ADDR_W-1:BREV_W];
  end
endmodule

// File: rtl/agu_circ.sv
module agu_circ #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 17
) (
  input  logic [ADDR_W-1:0] ptr,
  input  logic [ADDR_W-1:0] start,
  input  logic [LEN_W-1:0]  len,
  input  logic [ADDR_W-1:0] step,
  output logic [ADDR_W-1:0] nxt
);
  logic [ADDR_W-1:0] raw, rel, len_x;

  always_comb begin
    len_x = {{(ADDR_W-LEN_W){1'b0}}, len};
    raw   = ptr + step;
    rel   = raw - start;
    if (rel[ADDR_W-1])       nxt = raw + len_x;
    else if (rel >= len_x)   nxt = raw - len_x;
    else                     nxt = raw;
  end
endmodule

// File: rtl/agu_pipe.sv
module agu_pipe #(
  parameter int W       = 65,
  parameter int OUT_REG = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  if (OUT_REG != 0) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end
  end else begin : g_wire
    assign q = d;
  end
endmodule

// File: rtl/post_modify_agu.sv
module post_modify_agu
  import agu_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 17,
  parameter int CNT_W   = 7,
  parameter int BREV_W  = 16,
  parameter int OUT_REG = 1,
  localparam int SH_W   = $clog2(ADDR_W)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [MODE_W-1:0]    mode,
  input  logic [ADDR_W-1:0]    ptr,
  input  logic [ADDR_W-1:0]    imm,
  input  logic [ADDR_W-1:0]    idx,
  input  logic [SH_W-1:0]      shamt,
  input  logic [ADDR_W-1:0]    modr,
  input  logic [ADDR_W-1:0]    cstart,
  input  logic                 sz4,
  output logic [ADDR_W-1:0]    ea,
  output logic [ADDR_W-1:0]    new_ptr,
  output logic                 wb_en
);
  localparam int CNT_LSB = LEN_W;
  localparam int PIPE_W  = 2*ADDR_W + 1;

  function automatic logic [LEN_W-1:0] f_len(input logic [ADDR_W-1:0] mr);
    return mr[LEN_W-1:0];
  endfunction

  function automatic logic [ADDR_W-1:0] f_reg_step(input logic [ADDR_W-1:0] mr,
                                                   input logic big);
    logic [ADDR_W-1:0] ext;
    ext = {{(ADDR_W-CNT_W){mr[CNT_LSB+CNT_W-1]}}, mr[CNT_LSB +: CNT_W]};
    return big ? (ext << 2) : (ext << 1);
  endfunction

  function automatic logic [ADDR_W-1:0] f_scaled(input logic [ADDR_W-1:0] ix,
                                                 input logic [SH_W-1:0] sh,
                                                 input logic [ADDR_W-1:0] base);
    return (ix << sh) + base;
  endfunction

  // Named internal events, visible to the bound checker
  amode_e              m;
  logic [ADDR_W-1:0]   c_ea, c_newp, c_circ_step, rev_ptr, circ_nxt;
  logic [LEN_W-1:0]    c_len;
  logic                c_wb;

  assign m           = amode_e'(mode);
  assign c_len       = f_len(modr);
  assign c_circ_step = (m == AM_CIRCREG) ? f_reg_step(modr, sz4) : imm;

  agu_bitrev #(.ADDR_W(ADDR_W), .BREV_W(BREV_W)) u_rev (
    .din (ptr),
    .dout(rev_ptr)
  );

  agu_circ #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_circ (
    .ptr  (ptr),
    .start(cstart),
    .len  (c_len),
    .step (c_circ_step),
    .nxt  (circ_nxt)
  );

  always_comb begin
    c_ea   = '0;
    c_newp = ptr;
    c_wb   = 1'b0;
    unique case (m)
      AM_OFFSET:  c_ea = ptr + imm;
      AM_SCALED:  c_ea = f_scaled(idx, shamt, imm);
      AM_ABSSET:  begin c_ea = imm; c_newp = imm;        c_wb = 1'b1; end
      AM_POSTREG: begin c_ea = ptr; c_newp = ptr + modr; c_wb = 1'b1; end
      AM_POSTIMM: begin c_ea = ptr; c_newp = ptr + imm;  c_wb = 1'b1; end
      AM_BITREV:  begin c_ea = rev_ptr; c_newp = ptr + modr; c_wb = 1'b1; end
      AM_CIRCIMM,
      AM_CIRCREG: begin c_ea = ptr; c_newp = circ_nxt;   c_wb = 1'b1; end
      default: ;
    endcase
  end

  logic [PIPE_W-1:0] pipe_q;

  agu_pipe #(.W(PIPE_W), .OUT_REG(OUT_REG)) u_pipe (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({c_wb, c_newp, c_ea}),
    .q    (pipe_q)
  );

  assign {wb_en, new_ptr, ea} = pipe_q;
endmodule

// File: rtl/agu_sva.sv
module agu_sva
  import agu_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 17,
  parameter int BREV_W  = 16,
  parameter int OUT_REG = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [MODE_W-1:0] mode,
  input logic [ADDR_W-1:0] ptr,
  input logic [ADDR_W-1:0] cstart,
  input logic [ADDR_W-1:0] c_ea,
  input logic [ADDR_W-1:0] c_newp,
  input logic              c_wb,
  input logic [ADDR_W-1:0] c_circ_step,
  input logic [LEN_W-1:0]  c_len,
  input logic [ADDR_W-1:0] ea
);
  logic              armed;
  logic [ADDR_W-1:0] len_x, step_mag, ptr_rel, new_rel;
  logic              circ_mode, circ_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  always_comb begin
    len_x     = {{(ADDR_W-LEN_W){1'b0}}, c_len};
    step_mag  = c_circ_step[ADDR_W-1] ? (~c_circ_step + 1'b1) : c_circ_step;
    ptr_rel   = ptr - cstart;
    new_rel   = c_newp - cstart;
    circ_mode = (mode == AM_CIRCIMM) || (mode == AM_CIRCREG);
    circ_ok   = circ_mode && (c_len != '0) && (ptr_rel < len_x) && (step_mag <= len_x);
  end

  AST_OFFSET_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == AM_OFFSET) |-> (!c_wb && c_newp == ptr)); // R1

  AST_ABSSET_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == AM_ABSSET) |-> (c_wb && c_newp == c_ea)); // R3

  AST_BITREV_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == AM_BITREV) |-> (c_ea[ADDR_W-1:BREV_W] == ptr[ADDR_W-1:BREV_W])); // R6

  AST_CIRC_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    circ_ok |-> (new_rel < len_x)); // R10

  AST_INVALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[MODE_W-1]) |-> (!c_wb && c_ea == '0)); // R11

  if (OUT_REG != 0) begin : g_reg_chk
    AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (ea == $past(c_ea))); // R12
  end
endmodule

bind post_modify_agu agu_sva #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BREV_W(BREV_W), .OUT_REG(OUT_REG)
) u_sva (
  .clk(clk), .rst_n(rst_n), .mode(mode), .ptr(ptr), .cstart(cstart),
  .c_ea(c_ea), .c_newp(c_newp), .c_wb(c_wb), .c_circ_step(c_circ_step),
  .c_len(c_len), .ea(ea)
);

// File: tb/tb_post_modify_agu.sv
`timescale 1ns/1ps
module tb_post_modify_agu;
  localparam int AW = 32;
  localparam logic [31:0] BASE = 32'h0001_0000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    mode = '0;
  logic [AW-1:0] ptr = '0, imm = '0, idx = '0, modr = '0, cstart = '0;
  logic [4:0]    shamt = '0;
  logic          sz4 = 1'b0;
  logic [AW-1:0] ea, new_ptr;
  logic          wb_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  post_modify_agu dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .ptr(ptr), .imm(imm), .idx(idx),
    .shamt(shamt), .modr(modr), .cstart(cstart), .sz4(sz4),
    .ea(ea), .new_ptr(new_ptr), .wb_en(wb_en)
  );

  typedef struct {
    logic [31:0] ea;
    logic [31:0] np;
    logic        wb;
    string       tag;
  } exp_t;

  exp_t sb[$];

  // Independent reference model written from the requirements
  function automatic exp_t model(input logic [3:0] md, input logic [31:0] p,
                                 input logic [31:0] im, input logic [31:0] ix,
                                 input logic [4:0] sh, input logic [31:0] mr,
                                 input logic [31:0] cs, input logic big);
    exp_t r;
    longint len, st, off;
    logic [15:0] lo;
    r.ea = 0; r.np = p; r.wb = 0;
    len = longint'(mr & 32'h1FFFF);
    case (md)
      4'd0: r.ea = p + im;
      4'd1: r.ea = ix * (32'd1 << sh) + im;
      4'd2: begin r.ea = im; r.np = im; r.wb = 1; end
      4'd3: begin r.ea = p; r.np = p + mr; r.wb = 1; end
      4'd4: begin r.ea = p; r.np = p + im; r.wb = 1; end
      4'd5: begin
        lo = {<<{p[15:0]}};
        r.ea = {p[31:16], lo}; r.np = p + mr; r.wb = 1;
      end
      4'd6, 4'd7: begin
        if (md == 4'd6) st = longint'(signed'(im));
        else st = longint'(signed'(mr[23:17])) * (big ? 4 : 2);
        off = longint'(p) - longint'(cs) + st;
        if (off < 0) off += len;
        else if (off >= len) off -= len;
        r.ea = p; r.np = cs + 32'(off); r.wb = 1;
      end
      default: ;
    endcase
    return r;
  endfunction

  task automatic issue(input logic [3:0] md, input logic [31:0] p,
                       input logic [31:0] im, input logic [31:0] ix,
                       input logic [4:0] sh, input logic [31:0] mr,
                       input logic [31:0] cs, input logic big,
                       input string tag, output logic [31:0] nxt);
    exp_t e;
    @(negedge clk);
    mode = md; ptr = p; imm = im; idx = ix; shamt = sh; modr = mr;
    cstart = cs; sz4 = big;
    e = model(md, p, im, ix, sh, mr, cs, big);
    e.tag = tag;
    sb.push_back(e);
    nxt = e.np;
  endtask

  // Monitor: one result per cycle, one register stage behind the driver
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        checks++;
        if (ea !== e.ea || new_ptr !== e.np || wb_en !== e.wb) begin
          errors++;
          $display("FAIL %s: got ea=%h np=%h wb=%b, expected ea=%h np=%h wb=%b",
                   e.tag, ea, new_ptr, wb_en, e.ea, e.np, e.wb);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] p, dummy;
    // R12: reset values
    mode = 4'd2; imm = 32'hDEAD_BEEF;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (ea !== 0 || new_ptr !== 0 || wb_en !== 0) begin
      errors++;
      $display("FAIL R12 reset: got ea=%h np=%h wb=%b, expected 0 0 0", ea, new_ptr, wb_en);
    end
    @(negedge clk); rst_n = 1'b1;

    issue(4'd0, BASE, 32'd6, 0, 0, 0, 0, 0, "R1 offset +6", dummy);
    issue(4'd0, BASE, -32'sd4, 0, 0, 0, 0, 0, "R1 offset -4", dummy);
    issue(4'd1, BASE, BASE, 32'd3, 5'd2, 0, 0, 0, "R2 scaled 3<<2", dummy);
    issue(4'd1, 32'h55, BASE, 32'd7, 5'd1, 0, 0, 0, "R2 scaled 7<<1", dummy);
    issue(4'd2, 32'h1234, BASE + 4, 0, 0, 0, 0, 0, "R3 absolute set", dummy);

    p = BASE;
    for (int i = 0; i < 4; i++) issue(4'd3, p, 0, 0, 0, 32'd2, 0, 0, "R4 post reg", p);
    p = BASE;
    for (int i = 0; i < 4; i++) issue(4'd4, p, 32'd4, 0, 0, 0, 0, 0, "R5 post imm", p);
    p = BASE;
    for (int i = 0; i < 4; i++) issue(4'd5, p, 0, 0, 0, 32'h1000, 0, 0, "R6 R7 bitrev", p);
    issue(4'd5, 32'hABCD_0001, 0, 0, 0, 32'h1, 0, 0, "R6 bitrev upper bits", dummy);

    p = BASE;
    for (int i = 0; i < 4; i++) issue(4'd6, p, 32'd2, 0, 0, 32'd6, BASE, 0, "R8 circ imm", p);
    p = BASE;
    for (int i = 0; i < 4; i++)
      issue(4'd7, p, 0, 0, 0, (32'd2 << 17) | 32'd8, BASE, 0, "R9 circ reg size2", p);
    p = BASE;
    for (int i = 0; i < 4; i++)
      issue(4'd7, p, 0, 0, 0, (32'd1 << 17) | 32'd8, BASE, 1, "R9 circ reg size4", p);

    p = BASE;
    for (int i = 0; i < 3; i++) issue(4'd6, p, -32'sd2, 0, 0, 32'd6, BASE, 0, "R10 circ imm negative", p);
    p = BASE;
    for (int i = 0; i < 3; i++)
      issue(4'd7, p, 0, 0, 0, (32'h7F << 17) | 32'd8, BASE, 1, "R10 circ reg negative", p);

    issue(4'd8, BASE, 32'd9, 0, 0, 32'd1, 0, 0, "R11 invalid mode 8", dummy);
    issue(4'd15, BASE, 32'd9, 0, 0, 32'd1, 0, 0, "R11 invalid mode 15", dummy);

    repeat (4) @(posedge clk);
    #2;
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule